// File: doc/BRIEF.md
# UART Receiver with Status-Tagged Receive Queue

This block is the receive half of an asynchronous serial port. It watches a single serial input, and an enable pulse that occurs sixteen times per bit period tells it when to look. A falling edge opens a candidate start bit. The block confirms that start bit at its middle and then takes each following bit at its centre. It assembles a character of five to eight data bits, arriving least significant bit first. It checks an optional parity bit and the first stop bit. It also recognises a line held low for a whole character.

Each finished character goes into a sixteen-deep queue together with four flag bits. Software or a downstream engine reads the queue from its head with a read strobe. If a character arrives while the queue is full, the character is dropped. The loss is then recorded in the flags of the last entry the queue kept, so the overrun travels with the data instead of sitting in a separate register. The line format is set by a few static control inputs. The block captures those inputs when each character starts.

Top module: `uart_rx_tagged`

## Requirements
- R1: After reset the queue is empty: `empty`=1, `full`=0, `count`=0, and `head_data` reads zero.
- R2: A character begins only when `rx_line` is low on a tick and was high on the previous tick. On the 8th tick after that detection tick the line is sampled again. If it is high, the attempt is dropped and nothing is stored.
- R3: Data bits are sampled every 16 ticks after the start confirmation, least significant bit first. `cfg_wlen` codes 0,1,2,3 select 5,6,7,8 data bits. Bits that are not received read as zero in entry bits [7:0].
- R4: With `cfg_par_en`=1, one parity bit follows the data. `cfg_par_odd`=0 asks for an even count of ones over data plus parity, and 1 asks for an odd count. A mismatch sets entry bit 9. With `cfg_par_en`=0 no parity bit is taken and bit 9 stays 0.
- R5: Entry bit 8 (framing) is set when the first stop bit samples low. With `cfg_stop2`=1 the character is stored one bit period later, after a second stop bit that is not checked.
- R6: Entry bit 10 (break) is set when every data bit, the parity bit if enabled, and the first stop bit all sample low. After a break no new character can start until the line has been seen high.
- R7: The queue holds 16 entries and `head_data` shows the oldest one. `rd_en` removes the head when the queue is not empty and is ignored when it is empty. `count`, `empty` and `full` follow the occupancy.
- R8: When a character completes while the queue is full and `rd_en` is not removing an entry, the character is discarded and bit 11 (overrun) of the newest stored entry is set. If `rd_en` removes an entry in that same cycle, the new character is stored.
- R9: The line-format inputs are captured at start detection. Changing them in the middle of a character does not affect that character.
- R10: Cycles with `tick16` low do not advance reception. The result is the same for any spacing of ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_line | input | 1 | Serial input, idle high, already synchronous to clk |
| tick16 | input | 1 | Sixteen-times-bit-rate enable pulse |
| cfg_wlen | input | 2 | Data bits: 0..3 select 5..8 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_stop2 | input | 1 | Two stop bits |
| rd_en | input | 1 | Remove the head entry |
| head_data | output | 12 | Head entry {overrun, break, parity err, framing err, data[7:0]} |
| empty | output | 1 | Queue holds no entry |
| full | output | 1 | Queue holds 16 entries |
| count | output | 5 | Number of stored entries |

## Verification
The bench concentrates on a few corner cases:
- **Short low pulse.** A glitch shorter than half a bit must leave the queue untouched. A receiver that skipped the mid-start recheck would store a spurious character.
- **Break.** A held-low line must produce exactly one entry, 0x500. A receiver that re-armed without waiting for a high line would fill the queue with repeated breaks.
- **Overrun.** A seventeenth character sent into a full queue must change only the overrun flag of the sixteenth entry. A design that overwrote or shifted entries would show the wrong data when the queue is drained.
- **Format change mid-character.** Changing the format after the start bit must not alter the character in progress. A design using the live format would truncate it.
- **Sparse ticks.** Ticks arriving every third clock must give the same result. A design that counted clocks instead of ticks would misread the bits.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP1,
        ST_STOP2
    } rx_state_e;

    // Stored queue entry, most significant field first.
    typedef struct packed {
        logic       ovr;
        logic       brk;
        logic       perr;
        logic       ferr;
        logic [7:0] data;
    } rx_entry_t;

    typedef struct packed {
        logic [1:0] wlen;
        logic       par_en;
        logic       par_odd;
        logic       stop2;
    } rx_fmt_t;

endpackage

// File: rtl/uart_rx_deframer.sv
module uart_rx_deframer
    import uart_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      line,
    input  logic      tick,
    input  rx_fmt_t   fmt_in,
    output logic      push,
    output rx_entry_t push_entry
);

    localparam int            CW      = $clog2(OVS);
    localparam logic [CW-1:0] CNT_MID = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] CNT_BIT = CW'(OVS - 1);

    typedef struct packed {
        rx_state_e     st;
        logic [CW-1:0] cnt;
        logic [2:0]    idx;
        logic [7:0]    data;
        logic          par;
        logic          allz;
        logic          ferr;
        logic          prev;
        rx_fmt_t       fmt;
    } regs_t;

    regs_t      r_q, r_d;
    logic [2:0] last_idx;
    logic       done;
    logic       busy;

    always_comb begin
        last_idx = 3'd4 + {1'b0, r_q.fmt.wlen};
        busy     = (r_q.st != ST_IDLE);
    end

    always_comb begin
        r_d        = r_q;
        done       = 1'b0;
        push       = 1'b0;
        push_entry = '0;
        if (tick) begin
            r_d.prev = line;
            case (r_q.st)
                ST_IDLE: begin
                    if (r_q.prev && !line) begin
                        r_d.st   = ST_START;
                        r_d.cnt  = '0;
                        r_d.idx  = '0;
                        r_d.data = '0;
                        r_d.par  = 1'b0;
                        r_d.allz = 1'b1;
                        r_d.ferr = 1'b0;
                        r_d.fmt  = fmt_in;
                    end
                end
                ST_START: begin
                    if (r_q.cnt == CNT_MID) begin
                        r_d.cnt = '0;
                        r_d.st  = line ? ST_IDLE : ST_DATA;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                default: begin
                    if (r_q.cnt != CNT_BIT) begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end else begin
                        r_d.cnt = '0;
                        case (r_q.st)
                            ST_DATA: begin
                                r_d.data[r_q.idx] = line;
                                r_d.par           = r_q.par ^ line;
                                r_d.allz          = r_q.allz & ~line;
                                if (r_q.idx == last_idx) begin
                                    r_d.st = r_q.fmt.par_en ? ST_PAR : ST_STOP1;
                                end else begin
                                    r_d.idx = r_q.idx + 1'b1;
                                end
                            end
                            ST_PAR: begin
                                r_d.par  = r_q.par ^ line;
                                r_d.allz = r_q.allz & ~line;
                                r_d.st   = ST_STOP1;
                            end
                            ST_STOP1: begin
                                r_d.ferr = ~line;
                                r_d.allz = r_q.allz & ~line;
                                if (r_q.fmt.stop2) begin
                                    r_d.st = ST_STOP2;
                                end else begin
                                    done = 1'b1;
                                end
                            end
                            ST_STOP2: begin
                                done = 1'b1;
                            end
                            default: begin
                                r_d.st = ST_IDLE;
                            end
                        endcase
                    end
                end
            endcase
        end
        if (done) begin
            push            = 1'b1;
            push_entry.ovr  = 1'b0;
            push_entry.brk  = r_d.allz;
            push_entry.perr = r_q.fmt.par_en & (r_d.par ^ r_q.fmt.par_odd);
            push_entry.ferr = r_d.ferr;
            push_entry.data = r_d.data;
            r_d.st          = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    // R10: a character can only complete on a tick.
    a_r10_push_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> tick);

    // R6: a break always carries a framing error.
    a_r6_break_has_ferr: assert property (@(posedge clk) disable iff (!rst_n)
        (push && push_entry.brk) |-> push_entry.ferr);

    // R2: reception opens only from a low line.
    a_r2_start_from_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(line));

    // R9: the captured format is frozen while a character is in flight.
    a_r9_fmt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(r_q.fmt));

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNTW  = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  rx_entry_t       push_entry,
    input  logic            pop_req,
    output rx_entry_t       head,
    output logic            empty,
    output logic            full,
    output logic [CNTW-1:0] count
);

    localparam int              PW    = $clog2(DEPTH);
    localparam logic [PW-1:0]   LASTP = PW'(DEPTH - 1);
    localparam logic [CNTW-1:0] FULLC = CNTW'(DEPTH);

    typedef struct packed {
        rx_entry_t [DEPTH-1:0] mem;
        logic [PW-1:0]         wr;
        logic [PW-1:0]         rd;
        logic [CNTW-1:0]       cnt;
    } fifo_t;

    fifo_t s_q, s_d;
    logic  do_pop, do_push, do_ovr;

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == LASTP) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [PW-1:0] ptr_prev(input logic [PW-1:0] p);
        return (p == '0) ? LASTP : p - 1'b1;
    endfunction

    always_comb begin
        s_d     = s_q;
        do_pop  = pop_req && (s_q.cnt != '0);
        do_push = push && ((s_q.cnt != FULLC) || do_pop);
        do_ovr  = push && (s_q.cnt == FULLC) && !do_pop;
        if (do_pop) begin
            s_d.rd = ptr_next(s_q.rd);
        end
        if (do_push) begin
            s_d.mem[s_q.wr] = push_entry;
            s_d.wr          = ptr_next(s_q.wr);
        end
        if (do_ovr) begin
            s_d.mem[ptr_prev(s_q.wr)].ovr = 1'b1;
        end
        if (do_push && !do_pop) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end else if (do_pop && !do_push) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        empty = (s_q.cnt == '0);
        full  = (s_q.cnt == FULLC);
        count = s_q.cnt;
        head  = empty ? '0 : s_q.mem[s_q.rd];
    end

    // R7: occupancy never exceeds the depth.
    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULLC);

    // R7: a read with no arrival lowers the count by one.
    a_r7_pop_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !empty && !push) |=> (count == $past(count) - 1'b1));

    // R7: a read on an empty queue changes nothing.
    a_r7_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && empty && !push) |=> empty);

    // R8: an overrun leaves occupancy and the head entry untouched.
    a_r8_full_keeps_head: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop_req) |=> (full && head == $past(head)));

endmodule

// File: rtl/uart_rx_tagged.sv
module uart_rx_tagged
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int OVS   = 16,
    parameter int CNTW  = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_line,
    input  logic            tick16,
    input  logic [1:0]      cfg_wlen,
    input  logic            cfg_par_en,
    input  logic            cfg_par_odd,
    input  logic            cfg_stop2,
    input  logic            rd_en,
    output logic [11:0]     head_data,
    output logic            empty,
    output logic            full,
    output logic [CNTW-1:0] count
);

    rx_fmt_t   fmt;
    logic      push;
    rx_entry_t push_entry;
    rx_entry_t head;

    always_comb begin
        fmt.wlen    = cfg_wlen;
        fmt.par_en  = cfg_par_en;
        fmt.par_odd = cfg_par_odd;
        fmt.stop2   = cfg_stop2;
        head_data   = head;
    end

    uart_rx_deframer #(
        .OVS(OVS)
    ) u_deframer (
        .clk       (clk),
        .rst_n     (rst_n),
        .line      (rx_line),
        .tick      (tick16),
        .fmt_in    (fmt),
        .push      (push),
        .push_entry(push_entry)
    );

    uart_rx_fifo #(
        .DEPTH(DEPTH),
        .CNTW (CNTW)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_entry(push_entry),
        .pop_req   (rd_en),
        .head      (head),
        .empty     (empty),
        .full      (full),
        .count     (count)
    );

endmodule

// File: tb/uart_rx_tagged_bench.sv
module uart_rx_tagged_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_line = 1'b1;
    logic        tick16 = 1'b0;
    logic [1:0]  cfg_wlen = 2'd3;
    logic        cfg_par_en = 1'b0;
    logic        cfg_par_odd = 1'b0;
    logic        cfg_stop2 = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] head_data;
    logic        empty, full;
    logic [4:0]  count;

    int checks = 0;
    int errors = 0;
    int tick_div = 1;
    int cyc = 0;

    uart_rx_tagged u_uart_rx_tagged (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .tick16(tick16),
        .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_stop2(cfg_stop2), .rd_en(rd_en), .head_data(head_data),
        .empty(empty), .full(full), .count(count)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(negedge clk) begin
        cyc    = cyc + 1;
        tick16 = ((cyc % tick_div) == 0);
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [11:0] mq[$];
    bit          m_busy, m_prev, m_par, m_allz, m_fe, m_odd, m_fin;
    int          m_t, m_w, m_p, m_s2, m_k;
    logic [7:0]  m_d;
    logic [11:0] m_e;

    always @(posedge clk) begin
        m_fin = 1'b0;
        if (!rst_n) begin
            m_busy = 1'b0;
            m_prev = 1'b0;
            mq.delete();
        end else begin
            if (tick16) begin
                if (!m_busy) begin
                    if (m_prev && !rx_line) begin
                        m_busy = 1'b1; m_t = 0; m_w = 5 + int'(cfg_wlen);
                        m_p = int'(cfg_par_en); m_odd = cfg_par_odd; m_s2 = int'(cfg_stop2);
                        m_d = '0; m_par = 1'b0; m_allz = 1'b1; m_fe = 1'b0;
                    end
                end else begin
                    m_t++;
                    if (m_t == 8) begin
                        if (rx_line) m_busy = 1'b0;
                    end else if (m_t > 8 && ((m_t - 8) % 16) == 0) begin
                        m_k = (m_t - 8) / 16;
                        if (m_k <= m_w) begin
                            m_d[m_k-1] = rx_line; m_par ^= rx_line;
                            if (rx_line) m_allz = 1'b0;
                        end else if (m_p == 1 && m_k == m_w + 1) begin
                            m_par ^= rx_line;
                            if (rx_line) m_allz = 1'b0;
                        end else if (m_k == m_w + 1 + m_p) begin
                            m_fe = !rx_line;
                            if (rx_line) m_allz = 1'b0;
                            if (m_s2 == 0) m_fin = 1'b1;
                        end else begin
                            m_fin = 1'b1;
                        end
                    end
                end
                m_prev = rx_line;
            end
            if (rd_en && mq.size() > 0) void'(mq.pop_front());
            if (m_fin) begin
                m_busy = 1'b0;
                m_e = {1'b0, m_allz, (m_p == 1) && (m_par ^ m_odd), m_fe, m_d};
                if (mq.size() < 16) mq.push_back(m_e);
                else begin
                    m_e = mq[mq.size()-1];
                    m_e[11] = 1'b1;
                    mq[mq.size()-1] = m_e;
                end
            end
        end
    end

    // Compare on every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R7 count vs model", count, mq.size());
            chk("R7 empty vs model", empty, mq.size() == 0);
            chk("R7 full vs model", full, mq.size() == 16);
            chk("R7 head vs model", head_data, (mq.size() > 0) ? mq[0] : 12'h000);
        end
    end

    // ---------------- stimulus ----------------
    task automatic wait_ticks(input int n);
        int c = 0;
        while (c < n) begin
            @(posedge clk);
            if (tick16) c++;
        end
        @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic [1:0] wl, input bit pen,
                              input bit odd, input bit s2, input bit bad_par,
                              input bit stop_low, input bit scramble);
        int nb = 5 + int'(wl);
        logic p = odd;
        cfg_wlen = wl; cfg_par_en = pen; cfg_par_odd = odd; cfg_stop2 = s2;
        rx_line = 1'b0;
        wait_ticks(16);
        if (scramble) begin
            cfg_wlen = 2'd0; cfg_par_en = 1'b1; cfg_par_odd = 1'b1; cfg_stop2 = 1'b1;
        end
        for (int i = 0; i < nb; i++) begin
            rx_line = d[i];
            p = p ^ d[i];
            wait_ticks(16);
        end
        if (pen) begin
            rx_line = p ^ bad_par;
            wait_ticks(16);
        end
        rx_line = !stop_low;
        wait_ticks(16);
        if (s2) begin
            rx_line = 1'b1;
            wait_ticks(16);
        end
        rx_line = 1'b1;
        wait_ticks(3);
        cfg_wlen = wl; cfg_par_en = pen; cfg_par_odd = odd; cfg_stop2 = s2;
    endtask

    task automatic pop_check(input string tag, input logic [11:0] exp);
        chk(tag, head_data, exp);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state
        chk("R1 empty after reset", empty, 1);
        chk("R1 full after reset", full, 0);
        chk("R1 count after reset", count, 0);
        chk("R1 head after reset", head_data, 0);
        rst_n = 1'b1;
        wait_ticks(4);

        // R3: 8 data bits, LSB first
        send_frame(8'hA5, 2'd3, 0, 0, 0, 0, 0, 0);
        chk("R3 count after 8N1", count, 1);
        pop_check("R3 8-bit data", 12'h0A5);

        // R3: 5-bit word, upper bits zero
        send_frame(8'hFF, 2'd0, 0, 0, 0, 0, 0, 0);
        pop_check("R3 5-bit data", 12'h01F);

        // R4: good even parity, then bad odd parity
        send_frame(8'h53, 2'd2, 1, 0, 0, 0, 0, 0);
        pop_check("R4 even parity ok", 12'h053);
        send_frame(8'h2C, 2'd2, 1, 1, 0, 1, 0, 0);
        pop_check("R4 odd parity error", 12'h22C);

        // R5: framing error, then two stop bits clean
        send_frame(8'h15, 2'd1, 0, 0, 0, 0, 1, 0);
        pop_check("R5 framing error", 12'h115);
        send_frame(8'hC3, 2'd3, 0, 0, 1, 0, 0, 0);
        pop_check("R5 two stop bits", 12'h0C3);

        // R2: short glitch must store nothing
        rx_line = 1'b0;
        wait_ticks(4);
        rx_line = 1'b1;
        wait_ticks(40);
        chk("R2 glitch ignored", count, 0);

        // R6: break, one entry only
        cfg_wlen = 2'd3; cfg_par_en = 1'b0; cfg_stop2 = 1'b0;
        rx_line = 1'b0;
        wait_ticks(400);
        chk("R6 single break entry", count, 1);
        rx_line = 1'b1;
        wait_ticks(20);
        pop_check("R6 break entry", 12'h500);

        // R9: format changed mid character
        send_frame(8'h9E, 2'd3, 0, 0, 0, 0, 0, 1);
        pop_check("R9 format latched", 12'h09E);

        // R10: sparse ticks
        tick_div = 3;
        send_frame(8'h6B, 2'd3, 1, 1, 0, 0, 0, 0);
        pop_check("R10 sparse ticks", 12'h06B);
        tick_div = 1;
        wait_ticks(2);

        // R8: overrun tagging on the newest kept entry
        for (int i = 0; i < 17; i++) begin
            send_frame(8'(i + 8'h30), 2'd3, 0, 0, 0, 0, 0, 0);
        end
        chk("R7 full at 16", full, 1);
        chk("R7 count at 16", count, 16);
        for (int i = 0; i < 16; i++) begin
            pop_check((i == 15) ? "R8 overrun flag" : "R7 drain order",
                      {(i == 15), 3'b000, 8'(i + 8'h30)});
        end
        chk("R8 dropped char absent", empty, 1);

        // R7: read on empty queue
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
        chk("R7 empty read ignored", count, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule